// File: doc/BRIEF.md
# Filter Coefficient Download Engine

This block pushes a table of 16-bit filter coefficients into a remote device's coefficient store. The device has no direct window onto that store. Each coefficient is loaded indirectly through a handful of 8-bit registers behind a 12-bit register address. The block reads the coefficients one by one from a local RAM and turns each one into a fixed series of register writes: select the slot, send the two data bytes, strobe the commit bit, then issue two dummy writes that only serve as settling time. It hands every write to a separate register-write engine over a request/acknowledge pair.

A host pulses `start` together with the number of coefficients. The block first writes the filter-configuration register once, so that the filter clock runs and the gain is set. It then walks the coefficient indices upward from zero. When the last write is acknowledged it raises `done` for a single cycle and returns to idle.

Top module: `coef_loader`

## Requirements
- R1: After reset, `wr_req`, `busy` and `done` are all low.
- R2: The first write after an accepted start goes to address 0x065 with data 0xFA, and that value is written only once per run.
- R3: Each coefficient produces six writes in this order: 0x060 (slot index), 0x061 (low byte), 0x062 (high byte), 0x065 with data 0xFE (commit), then 0x064 with data 0x00 twice.
- R4: Coefficient k uses slot index k on 0x060. Its data bytes come from RAM word k, which the block reads through `ram_addr`/`ram_rd` with one cycle of read latency. Slots run from 0 to count-1 in ascending order.
- R5: Only one write is outstanding at a time. Once `wr_req` rises, it stays high with stable `wr_addr`/`wr_data` until a cycle with `wr_ack` high, and the next request is not raised before that.
- R6: A run with count N transfers exactly 1+6N writes. `done` is high for exactly one cycle, in the cycle after the last write is acknowledged.
- R7: A count of 0 produces only the configuration write, followed by `done`.
- R8: A start pulse that arrives while a run is in progress is ignored. The run carries on unchanged and signals `done` only once.
- R9: `busy` is high from the cycle after an accepted start until `done` is raised, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a download when idle |
| coef_count | input | CNT_W | Number of coefficients, 0..MAX_COEF |
| ram_rd | output | 1 | Read enable of the local coefficient RAM |
| ram_addr | output | IDX_W | Word address into the coefficient RAM |
| ram_data | input | 16 | RAM read data, valid one cycle after the address |
| wr_req | output | 1 | Register-write request |
| wr_addr | output | 12 | Register address of the pending write |
| wr_data | output | 8 | Data of the pending write |
| wr_ack | input | 1 | Write accepted in a cycle where `wr_req` is high |
| busy | output | 1 | Download in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with MAX_COEF = 8. At that size, every legal count from 0 up to the full table can be swept under three acknowledge timings: an immediate acknowledge, a fixed two-cycle wait, and a wait that changes from write to write. The RAM contents are computed from the slot number and a per-run seed, so a swapped byte or slot shows up as a data mismatch. The small table also makes it cheap to check a start pulse that arrives in the middle of a run.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;

  localparam int REG_AW  = 12;
  localparam int REG_DW  = 8;
  localparam int COEF_W  = 16;

  // indirect-access register map of the target device
  localparam logic [REG_AW-1:0] A_CFG = 12'h065;
  localparam logic [REG_AW-1:0] A_IDX = 12'h060;
  localparam logic [REG_AW-1:0] A_LO  = 12'h061;
  localparam logic [REG_AW-1:0] A_HI  = 12'h062;
  localparam logic [REG_AW-1:0] A_DLY = 12'h064;

  localparam logic [REG_DW-1:0] V_CFG_ON = 8'hFA;
  localparam logic [REG_DW-1:0] V_COMMIT = 8'hFE;
  localparam logic [REG_DW-1:0] V_DLY    = 8'h00;

  typedef enum logic [2:0] {
    ST_CFG, ST_IDX, ST_LO, ST_HI, ST_COMMIT, ST_DLY0, ST_DLY1
  } step_t;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_WAIT} fsm_t;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } wr_cmd_t;

endpackage

// File: rtl/coef_wr_port.sv
module coef_wr_port
  import coef_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  wr_cmd_t           cmd,
  input  logic              wr_ack,
  output logic              wr_req,
  output logic [REG_AW-1:0] wr_addr,
  output logic [REG_DW-1:0] wr_data,
  output logic              xfer
);

  assign xfer = wr_req & wr_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (cmd_valid) begin
      wr_req  <= 1'b1;
      wr_addr <= cmd.addr;
      wr_data <= cmd.data;
    end else if (xfer) begin
      wr_req  <= 1'b0;
    end
  end

  // R5: a pending request keeps its address and data until accepted
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R5: a new command is never loaded over an outstanding one
  p_single_out_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !wr_req);

endmodule

// File: rtl/coef_step_ctl.sv
module coef_step_ctl
  import coef_loader_pkg::*;
#(
  parameter int MAX_COEF = 128,
  localparam int CNT_W   = $clog2(MAX_COEF + 1),
  localparam int IDX_W   = (MAX_COEF > 1) ? $clog2(MAX_COEF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  coef_count,
  input  logic              xfer,
  input  logic [COEF_W-1:0] ram_data,
  output logic              cmd_valid,
  output wr_cmd_t           cmd,
  output logic              ram_rd,
  output logic [IDX_W-1:0]  ram_addr,
  output logic              busy,
  output logic              done
);

  fsm_t             state_q;
  step_t            step_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_coef;
  logic             fin;

  assign last_coef = (CNT_W'(idx_q) == cnt_q - CNT_W'(1));
  assign fin       = xfer && (state_q == S_WAIT) &&
                     (((step_q == ST_CFG) && (cnt_q == '0)) ||
                      ((step_q == ST_DLY1) && last_coef));

  // command for the current step; coefficient bytes come straight from RAM
  always_comb begin
    case (step_q)
      ST_CFG:    cmd = '{addr: A_CFG, data: V_CFG_ON};
      ST_IDX:    cmd = '{addr: A_IDX, data: REG_DW'(idx_q)};
      ST_LO:     cmd = '{addr: A_LO,  data: ram_data[7:0]};
      ST_HI:     cmd = '{addr: A_HI,  data: ram_data[15:8]};
      ST_COMMIT: cmd = '{addr: A_CFG, data: V_COMMIT};
      default:   cmd = '{addr: A_DLY, data: V_DLY};
    endcase
  end

  assign cmd_valid = (state_q == S_LOAD);
  assign ram_addr  = idx_q;
  assign ram_rd    = (state_q != S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      step_q  <= ST_CFG;
      idx_q   <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          cnt_q   <= coef_count;
          idx_q   <= '0;
          step_q  <= ST_CFG;
          state_q <= S_LOAD;
        end
        S_LOAD: state_q <= S_WAIT;
        default: if (xfer) begin
          if (fin) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= S_LOAD;
            case (step_q)
              ST_CFG:    step_q <= ST_IDX;
              ST_IDX:    step_q <= ST_LO;
              ST_LO:     step_q <= ST_HI;
              ST_HI:     step_q <= ST_COMMIT;
              ST_COMMIT: step_q <= ST_DLY0;
              ST_DLY0:   step_q <= ST_DLY1;
              default: begin
                step_q <= ST_IDX;
                idx_q  <= idx_q + 1'b1;
              end
            endcase
          end
        end
      endcase
    end
  end

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: the slot index never reaches the programmed count
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q != '0) |-> (CNT_W'(idx_q) < cnt_q));

  // R4: slots advance by exactly one between coefficients
  p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
    (xfer && busy && step_q == ST_DLY1 && !fin) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

  // R9: busy only rises in response to a start request
  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/coef_loader.sv
module coef_loader
  import coef_loader_pkg::*;
#(
  parameter int MAX_COEF = 128,
  localparam int CNT_W   = $clog2(MAX_COEF + 1),
  localparam int IDX_W   = (MAX_COEF > 1) ? $clog2(MAX_COEF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  coef_count,
  output logic              ram_rd,
  output logic [IDX_W-1:0]  ram_addr,
  input  logic [COEF_W-1:0] ram_data,
  output logic              wr_req,
  output logic [REG_AW-1:0] wr_addr,
  output logic [REG_DW-1:0] wr_data,
  input  logic              wr_ack,
  output logic              busy,
  output logic              done
);

  logic    cmd_valid;
  wr_cmd_t cmd;
  logic    xfer;

  coef_step_ctl #(.MAX_COEF(MAX_COEF)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .coef_count (coef_count),
    .xfer       (xfer),
    .ram_data   (ram_data),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .ram_rd     (ram_rd),
    .ram_addr   (ram_addr),
    .busy       (busy),
    .done       (done)
  );

  coef_wr_port u_port (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .wr_ack    (wr_ack),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xfer      (xfer)
  );

  // R6: done is only raised while no write is pending
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!wr_req && !busy));

endmodule

// File: tb/coef_loader_tb.sv
`timescale 1ns/1ps
module coef_loader_tb;
  localparam int MAXC  = 8;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int IDX_W = $clog2(MAXC);
  localparam int NREC  = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [CNT_W-1:0] coef_count = '0;
  logic             ram_rd;
  logic [IDX_W-1:0] ram_addr;
  logic [15:0]      ram_q = '0;
  logic             wr_req;
  logic [11:0]      wr_addr;
  logic [7:0]       wr_data;
  logic             wr_ack = 1'b0;
  logic             busy;
  logic             done;

  int checks = 0;
  int errors = 0;
  int lat_mode = 0;
  int seed = 0;
  int nrec = 0;
  int done_cnt = 0;
  int done_wide = 0;
  int hold_err = 0;
  int wcnt = 0;
  logic ack_new;
  logic prev_pend = 1'b0;
  logic prev_done = 1'b0;
  logic [11:0] prev_a;
  logic [7:0]  prev_d;
  logic [11:0] got_a [NREC];
  logic [7:0]  got_d [NREC];
  logic [11:0] exp_a [NREC];
  logic [7:0]  exp_d [NREC];

  coef_loader #(.MAX_COEF(MAXC)) u_dut (
    .clk(clk), .rst(rst), .start(start), .coef_count(coef_count),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_data(ram_q),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] coef_val(int k, int s);
    return 16'((k * 16'h3A17 + 16'h00C5 + s * 16'h0911) ^ (k << 9));
  endfunction

  always_ff @(posedge clk) if (ram_rd) ram_q <= coef_val(int'(ram_addr), seed);

  // acknowledge model and write monitor
  always @(negedge clk) begin
    if (rst) begin
      wr_ack <= 1'b0;
      wcnt = 0;
      prev_pend = 1'b0;
      prev_done = 1'b0;
    end else begin
      if (prev_pend && !(wr_req && wr_addr == prev_a && wr_data == prev_d)) hold_err++;
      if (wr_req) begin
        case (lat_mode)
          0: ack_new = 1'b1;
          1: ack_new = (wcnt >= 2);
          default: ack_new = (wcnt >= (nrec % 3));
        endcase
        wcnt++;
      end else begin
        ack_new = 1'b0;
        wcnt = 0;
      end
      if (wr_req && ack_new) begin
        if (nrec < NREC) begin
          got_a[nrec] = wr_addr;
          got_d[nrec] = wr_data;
        end
        nrec++;
      end
      prev_pend = wr_req && !ack_new;
      prev_a = wr_addr;
      prev_d = wr_data;
      if (done) done_cnt++;
      if (done && prev_done) done_wide++;
      prev_done = done;
      wr_ack <= ack_new;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic run(int n, bit restart_mid);
    int cyc;
    int total;
    int bad;
    string tag;
    total = 1 + 6 * n;
    exp_a[0] = 12'h065; exp_d[0] = 8'hFA;
    for (int k = 0; k < n; k++) begin
      logic [15:0] v;
      v = coef_val(k, seed);
      exp_a[1+6*k] = 12'h060; exp_d[1+6*k] = 8'(k);
      exp_a[2+6*k] = 12'h061; exp_d[2+6*k] = v[7:0];
      exp_a[3+6*k] = 12'h062; exp_d[3+6*k] = v[15:8];
      exp_a[4+6*k] = 12'h065; exp_d[4+6*k] = 8'hFE;
      exp_a[5+6*k] = 12'h064; exp_d[5+6*k] = 8'h00;
      exp_a[6+6*k] = 12'h064; exp_d[6+6*k] = 8'h00;
    end
    nrec = 0; done_cnt = 0; done_wide = 0; hold_err = 0;
    coef_count = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 3000) begin
      start = (restart_mid && cyc == 10);
      coef_count = restart_mid ? CNT_W'(1) : CNT_W'(n);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc < 3000, "R6", "done reached", cyc, 0);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9", "busy low after done", int'(busy), 0);
    check(nrec == total, n == 0 ? "R7" : "R6", "write count", nrec, total);
    check(done_cnt == 1 && done_wide == 0, restart_mid ? "R8" : "R6",
          "done pulses", done_cnt, 1);
    check(hold_err == 0, "R5", "request held until ack", hold_err, 0);
    bad = -1;
    for (int i = 0; i < total && i < nrec && i < NREC; i++)
      if (bad < 0 && (got_a[i] != exp_a[i] || got_d[i] != exp_d[i])) bad = i;
    if (bad < 0) tag = "R3";
    else if (bad == 0) tag = "R2";
    else if ((bad - 1) % 6 < 3) tag = "R4";
    else tag = "R3";
    if (bad < 0) check(1'b1, tag, "sequence", 0, 0);
    else check(1'b0, tag, "sequence addr/data at write",
               int'({got_a[bad], got_d[bad]}), int'({exp_a[bad], exp_d[bad]}));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(wr_req == 1'b0, "R1", "wr_req after reset", int'(wr_req), 0);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n <= MAXC; n++) begin
        lat_mode = m;
        seed = m * 16 + n;
        run(n, 1'b0);
      end
    end
    // R8: start while busy has no effect
    lat_mode = 2; seed = 77;
    run(5, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule